// File: doc/BRIEF.md
# Chainable performance event counter bank

This block holds a bank of 32-bit event counters and one dedicated cycle counter for a processor performance monitor. Each event counter has its own event-type register. The type picks which bit of a one-bit-per-code event input vector the counter counts. The code 0x00 instead makes the counter advance only on software-increment writes.

Two adjacent counters, an even one and the odd one above it, can be joined into one 64-bit counter. Writing the chain code into the odd counter's type register does this. The cycle counter is either 32 or 64 bits long, selected by a control bit.

Software reaches the block through a single-cycle register write port and a combinational read port. Each counter reports a wrap on its own bit of a one-cycle overflow pulse vector. Interrupt aggregation and privilege filtering belong to the blocks around this one.

Top module: `pmu_counter_bank`

## Requirements
- R1: After reset, every counter, type register, enable bit and control bit reads zero, and `ovf_o` is zero.
- R2: A counter advances only while control bit 0 (global enable, address 0x00) is set and its own bit in the enable register (address 0x01) is set. Event counter i uses bit i of the enable register and the cycle counter uses bit 31. While global enable is clear, no counter changes except by a register write, and no overflow pulse is raised.
- R3: An unchained event counter whose 10-bit type t lies in 1..63 and is not 0x1E increments by one at each clock edge where `evt_i[t]` is high. The counter wraps modulo 2^32. The wrap to zero raises `ovf_o[i]` for the one cycle after that edge, the same cycle in which the counter reads zero. Types of 64 and above never count.
- R4: A write to address 0x02 increments event counter i once for each set data bit i, provided the counter is enabled and its type is 0x00. `evt_i[0]` never counts. Bit 31 of the write has no effect on the cycle counter.
- R5: A software increment that wraps an unchained counter from 0xFFFFFFFF to zero raises that counter's overflow bit.
- R6: A pair 2k/2k+1 is chained while the odd counter's type is 0x1E. The 64-bit value is the odd counter in bits 63:32 and the even counter in bits 31:0. The even counter's type and enable decide when the pair counts, and each wrap of the even counter increments the odd counter.
- R7: In a chained pair, the even counter never raises an overflow pulse. The odd counter raises its overflow pulse when the 64-bit value wraps.
- R8: The cycle counter is read at 0x04 (low word) and 0x05 (high word), and it counts every enabled clock. With control bit 3 set, it is 64 bits wide and pulses `ovf_o[31]` on the 64-bit wrap. With bit 3 clear, the low word wraps on its own, the high word holds, and `ovf_o[31]` pulses on the low-word wrap.
- R9: A control write with data bit 1 set clears all event counters, and one with data bit 2 set clears the cycle counter. Both clears beat any count at the same edge, and both bits read back as zero.
- R10: A write to a counter's address (event counter i at 0x10+i) loads the data at that edge, in place of any count, and raises no overflow pulse for that counter.
- R11: Type register i reads at 0x20+i in bits 9:0. Control reads bit 0 (enable) and bit 3 (long cycle). Every unmapped address, and 0x02, reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 64 | One-cycle event pulses, one bit per event code |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 6 | Register read address |
| rd_data_o | output | 32 | Combinational read data |
| ovf_o | output | 32 | Overflow pulses: bit i for event counter i, bit 31 for the cycle counter |

## Verification
The checker watches several properties on every cycle. An idle, globally disabled bank holds still. A counter write takes priority and suppresses the overflow pulse. A chained low half never pulses overflow. A reset write clears the counters. A long-mode cycle counter steps by one, and a software-increment write leaves the cycle counter alone. Each overflow pulse coincides with a zero count. The carry from the low half into the high half, the even counter governing a pair, software increments gated by type and enable, and the short-mode cycle wrap all depend on sequences of register writes. Only the bench scenarios can show them, by comparing every readable register each cycle against a model.

// File: rtl/pmu_bank_pkg.sv
package pmu_bank_pkg;
    localparam int CW      = 32;
    localparam int TW      = 10;
    localparam int NCODES  = 64;
    localparam int CODE_W  = $clog2(NCODES);
    localparam int AW      = 6;
    localparam int CYC_IDX = 31;

    localparam logic [TW-1:0] EV_SWINC = 10'h000;
    localparam logic [TW-1:0] EV_CHAIN = 10'h01E;

    localparam logic [AW-1:0] A_CTRL     = 6'h00;
    localparam logic [AW-1:0] A_EN       = 6'h01;
    localparam logic [AW-1:0] A_SWINC    = 6'h02;
    localparam logic [AW-1:0] A_CYC_LO   = 6'h04;
    localparam logic [AW-1:0] A_CYC_HI   = 6'h05;
    localparam int            A_CNT_BASE = 16;
    localparam int            A_TYP_BASE = 32;

    localparam int CB_EN    = 0;
    localparam int CB_EVRST = 1;
    localparam int CB_CYRST = 2;
    localparam int CB_LONG  = 3;

    // per-counter command from the register port
    typedef struct packed {
        logic          clr;
        logic          ld;
        logic [CW-1:0] val;
    } cnt_cmd_t;

    function automatic logic evt_hit(logic [TW-1:0] t, logic [NCODES-1:0] ev);
        if (t == EV_SWINC || t == EV_CHAIN || t >= TW'(NCODES))
            return 1'b0;
        return ev[t[CODE_W-1:0]];
    endfunction
endpackage

// File: rtl/pmu_ctr32.sv
module pmu_ctr32
    import pmu_bank_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  cnt_cmd_t      cmd_i,
    input  logic          inc_i,
    input  logic          no_ovf_i,
    output logic [CW-1:0] q_o,
    output logic          carry_o,
    output logic          ovf_o
);
    always_comb carry_o = inc_i & ~cmd_i.clr & ~cmd_i.ld & (&q_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o   <= '0;
            ovf_o <= 1'b0;
        end else begin
            ovf_o <= carry_o & ~no_ovf_i;
            if (cmd_i.clr)
                q_o <= '0;
            else if (cmd_i.ld)
                q_o <= cmd_i.val;
            else if (inc_i)
                q_o <= q_o + 1'b1;
        end
    end
endmodule

// File: rtl/pmu_evt_pair.sv
module pmu_evt_pair
    import pmu_bank_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  glb_en_i,
    input  logic [1:0]            en_i,
    input  logic [1:0]            sw_i,
    input  logic [NCODES-1:0]     ev_i,
    input  cnt_cmd_t [1:0]        cmd_i,
    input  logic [1:0]            typ_we_i,
    input  logic [TW-1:0]         typ_wd_i,
    output logic [1:0][CW-1:0]    cnt_o,
    output logic [1:0][TW-1:0]    typ_o,
    output logic [1:0]            ovf_o,
    output logic                  chain_o
);
    logic [1:0] self_inc;
    logic [1:0] inc;
    logic [1:0] carry;

    always_comb chain_o = (typ_o[1] == EV_CHAIN);

    for (genvar g = 0; g < 2; g++) begin : g_half
        always_ff @(posedge clk) begin
            if (rst)
                typ_o[g] <= '0;
            else if (typ_we_i[g])
                typ_o[g] <= typ_wd_i;
        end

        always_comb
            self_inc[g] = glb_en_i & en_i[g] &
                          (evt_hit(typ_o[g], ev_i) | (sw_i[g] & (typ_o[g] == EV_SWINC)));
    end

    // the high half follows the low half's carry while chained
    always_comb begin
        inc[0] = self_inc[0];
        inc[1] = chain_o ? carry[0] : self_inc[1];
    end

    pmu_ctr32 u_lo (
        .clk(clk), .rst(rst), .cmd_i(cmd_i[0]), .inc_i(inc[0]),
        .no_ovf_i(chain_o), .q_o(cnt_o[0]), .carry_o(carry[0]), .ovf_o(ovf_o[0])
    );

    pmu_ctr32 u_hi (
        .clk(clk), .rst(rst), .cmd_i(cmd_i[1]), .inc_i(inc[1]),
        .no_ovf_i(1'b0), .q_o(cnt_o[1]), .carry_o(carry[1]), .ovf_o(ovf_o[1])
    );
endmodule

// File: rtl/pmu_cyc_ctr.sv
module pmu_cyc_ctr
    import pmu_bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cnt_en_i,
    input  logic            long_i,
    input  logic            clr_i,
    input  logic            ld_lo_i,
    input  logic            ld_hi_i,
    input  logic [CW-1:0]   wd_i,
    output logic [2*CW-1:0] q_o,
    output logic            ovf_o
);
    logic inc;
    logic wrap;

    always_comb begin
        inc  = cnt_en_i & ~clr_i & ~ld_lo_i & ~ld_hi_i;
        wrap = long_i ? (&q_o) : (&q_o[CW-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o   <= '0;
            ovf_o <= 1'b0;
        end else begin
            ovf_o <= inc & wrap;
            if (clr_i)
                q_o <= '0;
            else if (ld_lo_i)
                q_o[CW-1:0] <= wd_i;
            else if (ld_hi_i)
                q_o[2*CW-1:CW] <= wd_i;
            else if (inc) begin
                if (long_i)
                    q_o <= q_o + 1'b1;
                else
                    q_o[CW-1:0] <= q_o[CW-1:0] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pmu_counter_bank.sv
module pmu_counter_bank
    import pmu_bank_pkg::*;
#(
    parameter int N_EVT = 6  // even, at most 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCODES-1:0] evt_i,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [CW-1:0]     wr_data_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [CW-1:0]     rd_data_o,
    output logic [CW-1:0]     ovf_o
);
    localparam int N_PAIR = N_EVT / 2;

    logic                     glb_en;
    logic                     cyc_long;
    logic                     cyc_en;
    logic [N_EVT-1:0]         cnt_en;
    logic                     wr_ctrl;
    logic [N_EVT-1:0]         sw;
    logic [N_EVT-1:0]         typ_we;
    cnt_cmd_t [N_EVT-1:0]     cmd;
    logic [N_EVT-1:0][CW-1:0] cnt_flat;
    logic [N_EVT-1:0][TW-1:0] typ_flat;
    logic [N_EVT-1:0]         evt_ovf;
    logic [N_PAIR-1:0]        pair_chain;
    logic [2*CW-1:0]          cyc_q;
    logic                     cyc_ovf;

    always_comb wr_ctrl = wr_en_i & (wr_addr_i == A_CTRL);

    for (genvar i = 0; i < N_EVT; i++) begin : g_dec
        always_comb begin
            sw[i]      = wr_en_i & (wr_addr_i == A_SWINC) & wr_data_i[i];
            typ_we[i]  = wr_en_i & (wr_addr_i == AW'(A_TYP_BASE + i));
            cmd[i].clr = wr_ctrl & wr_data_i[CB_EVRST];
            cmd[i].ld  = wr_en_i & (wr_addr_i == AW'(A_CNT_BASE + i));
            cmd[i].val = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            glb_en   <= 1'b0;
            cyc_long <= 1'b0;
            cyc_en   <= 1'b0;
            cnt_en   <= '0;
        end else begin
            if (wr_ctrl) begin
                glb_en   <= wr_data_i[CB_EN];
                cyc_long <= wr_data_i[CB_LONG];
            end
            if (wr_en_i && wr_addr_i == A_EN) begin
                cnt_en <= wr_data_i[N_EVT-1:0];
                cyc_en <= wr_data_i[CYC_IDX];
            end
        end
    end

    for (genvar k = 0; k < N_PAIR; k++) begin : g_pair
        logic [1:0][CW-1:0] pc;
        logic [1:0][TW-1:0] pt;
        logic [1:0]         po;

        pmu_evt_pair u_pair (
            .clk      (clk),
            .rst      (rst),
            .glb_en_i (glb_en),
            .en_i     (cnt_en[2*k+1 -: 2]),
            .sw_i     (sw[2*k+1 -: 2]),
            .ev_i     (evt_i),
            .cmd_i    (cmd[2*k+1 -: 2]),
            .typ_we_i (typ_we[2*k+1 -: 2]),
            .typ_wd_i (wr_data_i[TW-1:0]),
            .cnt_o    (pc),
            .typ_o    (pt),
            .ovf_o    (po),
            .chain_o  (pair_chain[k])
        );

        assign cnt_flat[2*k]   = pc[0];
        assign cnt_flat[2*k+1] = pc[1];
        assign typ_flat[2*k]   = pt[0];
        assign typ_flat[2*k+1] = pt[1];
        assign evt_ovf[2*k]    = po[0];
        assign evt_ovf[2*k+1]  = po[1];
    end

    pmu_cyc_ctr u_cyc (
        .clk      (clk),
        .rst      (rst),
        .cnt_en_i (glb_en & cyc_en),
        .long_i   (cyc_long),
        .clr_i    (wr_ctrl & wr_data_i[CB_CYRST]),
        .ld_lo_i  (wr_en_i & (wr_addr_i == A_CYC_LO)),
        .ld_hi_i  (wr_en_i & (wr_addr_i == A_CYC_HI)),
        .wd_i     (wr_data_i),
        .q_o      (cyc_q),
        .ovf_o    (cyc_ovf)
    );

    always_comb begin
        ovf_o              = '0;
        ovf_o[N_EVT-1:0]   = evt_ovf;
        ovf_o[CYC_IDX]     = cyc_ovf;
    end

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            A_CTRL: begin
                rd_data_o[CB_EN]   = glb_en;
                rd_data_o[CB_LONG] = cyc_long;
            end
            A_EN: begin
                rd_data_o[N_EVT-1:0] = cnt_en;
                rd_data_o[CYC_IDX]   = cyc_en;
            end
            A_CYC_LO: rd_data_o = cyc_q[CW-1:0];
            A_CYC_HI: rd_data_o = cyc_q[2*CW-1:CW];
            default:  rd_data_o = '0;
        endcase
        for (int i = 0; i < N_EVT; i++) begin
            if (rd_addr_i == AW'(A_CNT_BASE + i))
                rd_data_o = cnt_flat[i];
            if (rd_addr_i == AW'(A_TYP_BASE + i))
                rd_data_o = {{(CW-TW){1'b0}}, typ_flat[i]};
        end
    end
endmodule

// File: rtl/pmu_counter_bank_chk.sv
module pmu_counter_bank_chk
    import pmu_bank_pkg::*;
#(
    parameter int N_EVT = 6
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_en_i,
    input logic [AW-1:0]            wr_addr_i,
    input logic [CW-1:0]            wr_data_i,
    input logic                     glb_en,
    input logic                     cyc_en,
    input logic                     cyc_long,
    input logic [N_EVT-1:0][CW-1:0] cnt_flat,
    input logic [2*CW-1:0]          cyc_q,
    input logic [N_EVT/2-1:0]       pair_chain,
    input logic [CW-1:0]            ovf_o
);
    // R2: a disabled bank with no write holds every counter and stays quiet
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!glb_en && !wr_en_i) |=> ($stable(cnt_flat) && $stable(cyc_q) && ovf_o == '0));

    // R9: event reset write clears the event counters
    p_evt_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_addr_i == A_CTRL && wr_data_i[CB_EVRST]) |=> (cnt_flat == '0));

    // R8: long cycle counter steps by one when enabled and untouched
    p_cyc_step_r8: assert property (@(posedge clk) disable iff (rst)
        (glb_en && cyc_en && cyc_long && !wr_en_i) |=> (cyc_q == $past(cyc_q) + 1'b1));

    // R4: a software-increment write never moves a stopped cycle counter
    p_swinc_cyc_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_addr_i == A_SWINC && !(glb_en && cyc_en)) |=> $stable(cyc_q));

    for (genvar i = 0; i < N_EVT; i++) begin : g_cnt
        // R10: a counter write wins over a count and raises no overflow
        p_wr_wins_r10: assert property (@(posedge clk) disable iff (rst)
            (wr_en_i && wr_addr_i == AW'(A_CNT_BASE + i)) |=>
            (cnt_flat[i] == $past(wr_data_i) && !ovf_o[i]));

        // R3: an overflow pulse coincides with a zero count
        p_ovf_zero_r3: assert property (@(posedge clk) disable iff (rst)
            ovf_o[i] |-> (cnt_flat[i] == '0));
    end

    for (genvar k = 0; k < N_EVT / 2; k++) begin : g_pair
        // R7: the low half of a chained pair never reports overflow
        p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
            pair_chain[k] |=> !ovf_o[2*k]);
    end
endmodule

bind pmu_counter_bank pmu_counter_bank_chk #(.N_EVT(N_EVT)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .glb_en     (glb_en),
    .cyc_en     (cyc_en),
    .cyc_long   (cyc_long),
    .cnt_flat   (cnt_flat),
    .cyc_q      (cyc_q),
    .pair_chain (pair_chain),
    .ovf_o      (ovf_o)
);

// File: tb/pmu_counter_bank_tb_top.sv
`timescale 1ns/10ps
module pmu_counter_bank_tb_top;
    localparam int N = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] evt_i = '0;
    logic        wr_en_i = 1'b0;
    logic [5:0]  wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [5:0]  rd_addr_i = '0;
    logic [31:0] rd_data_o;
    logic [31:0] ovf_o;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    logic [31:0] m_cnt [N];
    logic [9:0]  m_typ [N];
    logic [N-1:0] m_en;
    logic        m_cyen, m_glb, m_long;
    logic [63:0] m_cyc;
    logic [31:0] m_ovf;

    pmu_counter_bank #(.N_EVT(N)) dut_i (
        .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .ovf_o(ovf_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input int a);
        logic [31:0] v = '0;
        if (a == 0) begin v[0] = m_glb; v[3] = m_long; end
        else if (a == 1) begin v[N-1:0] = m_en; v[31] = m_cyen; end
        else if (a == 4) v = m_cyc[31:0];
        else if (a == 5) v = m_cyc[63:32];
        else if (a >= 16 && a < 16 + N) v = m_cnt[a-16];
        else if (a >= 32 && a < 32 + N) v = {22'd0, m_typ[a-32]};
        return v;
    endfunction

    function automatic logic m_inc(input int i, input logic sw, input logic [31:0] wd, input logic [63:0] ev);
        logic [9:0] t = m_typ[i];
        logic hw = (t >= 10'd1 && t < 10'd64 && t != 10'h1E) ? ev[t[5:0]] : 1'b0;
        return m_glb && m_en[i] && ((t == 10'd0 && sw && wd[i]) || hw);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin m_cnt[i] = '0; m_typ[i] = '0; end
        m_en = '0; m_cyen = 0; m_glb = 0; m_long = 0; m_cyc = '0; m_ovf = '0;
    endtask

    task automatic step(input logic we, input logic [5:0] wa, input logic [31:0] wd,
                        input logic [63:0] ev, input string tag);
        logic [31:0] nc [N];
        logic [9:0]  nt [N];
        logic [31:0] no = '0;
        logic [63:0] ncy = m_cyc;
        logic wctrl = we && wa == 6'h00;
        logic sw    = we && wa == 6'h02;
        logic evrst = wctrl && wd[1];
        logic cyrst = wctrl && wd[2];
        for (int i = 0; i < N; i++) begin nc[i] = m_cnt[i]; nt[i] = m_typ[i]; end
        for (int k = 0; k < N / 2; k++) begin
            int lo = 2 * k;
            int hi = 2 * k + 1;
            logic ch = (m_typ[hi] == 10'h1E);
            logic carry = 0;
            logic ih;
            if (evrst) nc[lo] = '0;
            else if (we && wa == 6'(16 + lo)) nc[lo] = wd;
            else if (m_inc(lo, sw, wd, ev)) begin
                nc[lo] = m_cnt[lo] + 1;
                if (m_cnt[lo] == 32'hFFFF_FFFF) begin
                    if (ch) carry = 1; else no[lo] = 1;
                end
            end
            ih = ch ? carry : m_inc(hi, sw, wd, ev);
            if (evrst) nc[hi] = '0;
            else if (we && wa == 6'(16 + hi)) nc[hi] = wd;
            else if (ih) begin
                nc[hi] = m_cnt[hi] + 1;
                if (m_cnt[hi] == 32'hFFFF_FFFF) no[hi] = 1;
            end
        end
        if (cyrst) ncy = '0;
        else if (we && wa == 6'h04) ncy[31:0] = wd;
        else if (we && wa == 6'h05) ncy[63:32] = wd;
        else if (m_glb && m_cyen) begin
            if (m_long) begin
                if (&m_cyc) no[31] = 1;
                ncy = m_cyc + 1;
            end else begin
                if (&m_cyc[31:0]) no[31] = 1;
                ncy[31:0] = m_cyc[31:0] + 1;
            end
        end
        for (int i = 0; i < N; i++)
            if (we && wa == 6'(32 + i)) nt[i] = wd[9:0];
        wr_en_i = we; wr_addr_i = wa; wr_data_i = wd; evt_i = ev;
        @(posedge clk);
        #1;
        wr_en_i = 0; evt_i = '0;
        for (int i = 0; i < N; i++) begin m_cnt[i] = nc[i]; m_typ[i] = nt[i]; end
        m_cyc = ncy; m_ovf = no;
        if (wctrl) begin m_glb = wd[0]; m_long = wd[3]; end
        if (we && wa == 6'h01) begin m_en = wd[N-1:0]; m_cyen = wd[31]; end
        check(tag, "ovf_o", ovf_o, m_ovf);
        for (int a = 0; a < 64; a++) begin
            rd_addr_i = 6'(a);
            #0.05;
            check(tag, $sformatf("rd[%0h]", a), rd_data_o, exp_rd(a));
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input string tag);
        step(1'b1, a, d, '0, tag);
    endtask

    task automatic idle(input logic [63:0] ev, input string tag);
        step(1'b0, 6'h00, 32'h0, ev, tag);
    endtask

    initial begin
        #1_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        idle('0, "R1");

        // register map and gating
        wr(6'h20, 32'h0000_0005, "R11");
        wr(6'h21, 32'hFFFF_FC00, "R11");      // type 0 in bits 9:0
        wr(6'h01, 32'h8000_003F, "R2");
        idle(64'h20, "R2");                    // global enable still clear
        wr(6'h00, 32'h0000_0001, "R2");
        idle(64'h20, "R3");
        idle(64'h20, "R3");
        idle(64'h01, "R4");                    // code 0 hardware input ignored
        wr(6'h10, 32'hFFFF_FFFE, "R10");
        idle(64'h20, "R3");
        idle(64'h20, "R3");                    // wraps, overflow pulse
        step(1'b1, 6'h10, 32'h0000_0100, 64'h20, "R10");
        wr(6'h24, 32'h0000_0050, "R3");        // type 80 never counts
        idle(64'hFFFF_FFFF_FFFF_FFFF, "R3");

        // software increment
        wr(6'h11, 32'hFFFF_FFFE, "R4");
        wr(6'h02, 32'h8000_0002, "R4");
        wr(6'h02, 32'h0000_0002, "R5");
        wr(6'h02, 32'h0000_0001, "R4");        // counter 0 type is not swinc

        // chained pair
        wr(6'h22, 32'h0000_0007, "R6");
        wr(6'h23, 32'h0000_001E, "R6");
        wr(6'h12, 32'hFFFF_FFFF, "R6");
        wr(6'h13, 32'h0000_0004, "R6");
        idle(64'h80, "R6");
        wr(6'h01, 32'h8000_0037, "R6");        // odd enable cleared, even governs
        wr(6'h12, 32'hFFFF_FFFF, "R6");
        idle(64'h80, "R6");
        wr(6'h12, 32'hFFFF_FFFF, "R7");
        wr(6'h13, 32'hFFFF_FFFF, "R7");
        idle(64'h80, "R7");
        idle(64'h80, "R7");

        // cycle counter
        wr(6'h05, 32'h0000_0005, "R8");
        wr(6'h04, 32'hFFFF_FFFD, "R8");
        repeat (4) idle('0, "R8");
        wr(6'h00, 32'h0000_0009, "R8");
        wr(6'h05, 32'hFFFF_FFFF, "R8");
        wr(6'h04, 32'hFFFF_FFFE, "R8");
        repeat (3) idle('0, "R8");

        // resets
        wr(6'h00, 32'h0000_000F, "R9");
        wr(6'h00, 32'h0000_0001, "R9");
        wr(6'h00, 32'h0000_0003, "R9");

        // constrained random mix
        for (int n = 0; n < 2500; n++) begin
            int op = $urandom % 10;
            logic [63:0] ev = {$urandom, $urandom};
            logic [31:0] d;
            if (op == 3) begin
                int c = $urandom % 6;
                d = (c == 0) ? 32'h0 : (c == 1) ? 32'h1E : (c == 2) ? 32'h41 : 32'($urandom % 8);
                step(1'b1, 6'(32 + $urandom % N), d, ev, "R6");
            end else if (op == 4) begin
                d = ($urandom % 2) ? (32'hFFFF_FFF8 | 32'($urandom % 8)) : $urandom;
                step(1'b1, 6'(16 + $urandom % N), d, ev, "R10");
            end else if (op == 5 || op == 6) begin
                step(1'b1, 6'h02, $urandom, ev, "R4");
            end else if (op == 7) begin
                d = $urandom | 32'h8000_0000;
                step(1'b1, 6'h01, d, ev, "R2");
            end else if (op == 8 && ($urandom % 4) == 0) begin
                d = {28'd0, 1'($urandom), 1'(($urandom % 8) == 0), 1'(($urandom % 8) == 0),
                     1'(($urandom % 5) != 0)};
                step(1'b1, 6'h00, d, ev, "R9");
            end else if (op == 9 && ($urandom % 4) == 0) begin
                step(1'b1, ($urandom % 2) ? 6'h04 : 6'h05, 32'hFFFF_FFF0 | 32'($urandom % 16), ev, "R8");
            end else begin
                step(1'b0, 6'h00, 32'h0, ev, "R3");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule